// File: doc/BRIEF.md
# Clock Configuration Register Bank

This block holds the configuration words of a chip's clock controller: the operating-mode word, three divider words, three PLL control words, a clock-output select word, three gating words, a wake-mask word and a group of load, voltage and power-management words. Software reaches it over a simple word-wide bus with separate read and write strobes. Each access is either accepted or rejected. The response comes back one cycle later as a registered read word with a valid pulse and an error pulse. The block spans a 4 KB byte window, and the word index is the byte address with its two low bits dropped.

Each word has its own reset value and its own mask of writable bits. Eight words can be written. The others keep their reset contents whatever the bus does. The mode word has one bit, bit 26, that is forced to one on every write. The response path is a three-state machine. From `RSP_IDLE` (no access last cycle) it can move to `RSP_OK` (an accepted access last cycle) or to `RSP_FAULT` (a rejected access last cycle). Every state can move to any of the three on each cycle: to `RSP_IDLE` when neither strobe is high, to `RSP_FAULT` when the access is rejected, and to `RSP_OK` otherwise.

Top module: `clkcfg_regbank`

## Requirements
- R1: After reset, reading word indices 0..25 returns, in index order: 0x074B0B7D, 0xFF870B48, 0x49FCFE7F, 0x007F0000, 0x04001800, 0x04051C03, 0x04043001, 0x00000280, 0xFFFFFFFF (indices 8, 9, 10 and 11), 0 (indices 12 to 17), 0x00004040 (index 18), 0 (indices 19 to 22), 0x80209828, 0x00AA0000, 0x00000285. While reset is held, `rsp_vld`, `err` and `rdata` are 0.
- R2: The word index is `addr[11:2]`. An access with `addr[1:0]` not zero is rejected. A rejected read returns zero, a rejected write changes nothing, and either one raises `err`.
- R3: A read strobe in cycle n gives `rsp_vld` = 1 and the word in `rdata` in cycle n+1.
- R4: A write to index 0 stores (wdata AND 0x3B6FDFFF) OR 0x04000000, so bit 26 always reads back as 1.
- R5: A write to index 1 stores wdata AND 0xFF9F3FFF. A write to index 4 or index 6 stores wdata AND 0xBFFF3FFF.
- R6: A write to index 2, 8, 9 or 10 stores all 32 bits of wdata.
- R7: A write to any other index below 26 leaves every word unchanged and raises `err` in the response cycle.
- R8: A read of index 26 or above returns 0 with `err` = 1.
- R9: A write to index 26 or above leaves every word unchanged and raises `err`.
- R10: `rsp_vld` is high for exactly the cycles that follow a cycle with a strobe. `err` is high only together with `rsp_vld`, and only for the response to a rejected access.
- R11: When both strobes are high in one cycle, the read returns the contents before that write, the write still takes effect, and `err` is raised if either access is rejected.
- R12: A word written in cycle n reads back its new value through a read strobe in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, zero when no read was accepted |
| rsp_vld | output | 1 | Response valid, one cycle after a strobe |
| err | output | 1 | Access rejected, pulses with `rsp_vld` |

## Verification
A read and a write can land in the same cycle, and a write can be followed at once by a read of the same word. The bench raises both strobes together on the same address. It does this on writable words, read-only words, out-of-range indices and misaligned addresses, and checks that the read sees the older contents, that the new value appears on the next read, and that the error pulse is the OR of the two verdicts. A long run of random mixed accesses is then judged cycle by cycle against a behavioural model of the word array.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int DATA_W = 32;
    localparam int NREG   = 26;
    localparam int RIDX_W = $clog2(NREG);

    // Response phase of the bus port
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_OK    = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

    // Value each word takes at reset
    function automatic logic [DATA_W-1:0] init_word(input int i);
        logic [DATA_W-1:0] v;
        case (i)
            0:       v = 32'h074B_0B7D;
            1:       v = 32'hFF87_0B48;
            2:       v = 32'h49FC_FE7F;
            3:       v = 32'h007F_0000;
            4:       v = 32'h0400_1800;
            5:       v = 32'h0405_1C03;
            6:       v = 32'h0404_3001;
            7:       v = 32'h0000_0280;
            8, 9, 10, 11: v = 32'hFFFF_FFFF;
            18:      v = 32'h0000_4040;
            23:      v = 32'h8020_9828;
            24:      v = 32'h00AA_0000;
            25:      v = 32'h0000_0285;
            default: v = '0;
        endcase
        return v;
    endfunction

    // Bits a bus write may change; zero means the word is read-only
    function automatic logic [DATA_W-1:0] wr_mask(input int i);
        logic [DATA_W-1:0] m;
        case (i)
            0:            m = 32'h3B6F_DFFF;
            1:            m = 32'hFF9F_3FFF;
            4, 6:         m = 32'hBFFF_3FFF;
            2, 8, 9, 10:  m = 32'hFFFF_FFFF;
            default:      m = '0;
        endcase
        return m;
    endfunction

    // Bits forced high on every write
    function automatic logic [DATA_W-1:0] wr_force(input int i);
        return (i == 0) ? 32'h0400_0000 : '0;
    endfunction

    function automatic logic is_writable(input int i);
        return wr_mask(i) != '0;
    endfunction

endpackage

// File: rtl/clkcfg_decode.sv
module clkcfg_decode
    import clkcfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [RIDX_W-1:0] ridx,
    output logic              rd_go,
    output logic              wr_go,
    output logic              rd_bad,
    output logic              wr_bad
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

    logic [IDX_W-1:0] idx_full;
    logic             aligned;
    logic             in_range;
    logic             writable;

    always_comb begin
        idx_full = addr[ADDR_W-1:2];
        aligned  = (addr[1:0] == 2'b00);
        in_range = aligned && (idx_full <= LAST_IDX);
        ridx     = idx_full[RIDX_W-1:0];
        writable = in_range && is_writable(int'(ridx));
        rd_go    = rd_en && in_range;
        wr_go    = wr_en && writable;
        rd_bad   = rd_en && !in_range;
        wr_bad   = wr_en && !writable;
    end

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic              wr_go,
    input  logic [RIDX_W-1:0] ridx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [NREG];
    logic [DATA_W-1:0] rd_word;

    for (genvar g = 0; g < NREG; g++) begin : g_word
        localparam logic [DATA_W-1:0] INIT = init_word(g);
        localparam logic [DATA_W-1:0] MASK = wr_mask(g);
        localparam logic [DATA_W-1:0] SETB = wr_force(g);

        if (MASK != '0) begin : g_rw
            logic [DATA_W-1:0] q;
            logic              hit;
            assign hit = wr_go && (ridx == RIDX_W'(g));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= INIT;
                end else if (hit) begin
                    q <= (wdata & MASK) | SETB;
                end
            end
            assign words[g] = q;
        end else begin : g_ro
            assign words[g] = INIT;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NREG; i++) begin
            if (ridx == RIDX_W'(i)) begin
                rd_word = words[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd_go ? rd_word : '0;
        end
    end

endmodule

// File: rtl/clkcfg_rsp_fsm.sv
module clkcfg_rsp_fsm
    import clkcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic wr_en,
    input  logic rd_bad,
    input  logic wr_bad,
    output logic rsp_vld,
    output logic err
);

    rsp_state_e st, st_nxt;
    rsp_state_e verdict;

    always_comb begin
        if (!(rd_en || wr_en)) begin
            verdict = RSP_IDLE;
        end else if (rd_bad || wr_bad) begin
            verdict = RSP_FAULT;
        end else begin
            verdict = RSP_OK;
        end
    end

    always_comb begin
        unique case (st)
            RSP_IDLE:  st_nxt = verdict;
            RSP_OK:    st_nxt = verdict;
            RSP_FAULT: st_nxt = verdict;
            default:   st_nxt = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= RSP_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        unique case (st)
            RSP_OK: begin
                rsp_vld = 1'b1;
                err     = 1'b0;
            end
            RSP_FAULT: begin
                rsp_vld = 1'b1;
                err     = 1'b1;
            end
            default: begin
                rsp_vld = 1'b0;
                err     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rsp_vld,
    output logic              err
);

    logic [RIDX_W-1:0] ridx;
    logic              rd_go;
    logic              wr_go;
    logic              rd_bad;
    logic              wr_bad;

    clkcfg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .ridx   (ridx),
        .rd_go  (rd_go),
        .wr_go  (wr_go),
        .rd_bad (rd_bad),
        .wr_bad (wr_bad)
    );

    clkcfg_regfile u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_go (rd_go),
        .wr_go (wr_go),
        .ridx  (ridx),
        .wdata (wdata),
        .rdata (rdata)
    );

    clkcfg_rsp_fsm u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .rd_bad  (rd_bad),
        .wr_bad  (wr_bad),
        .rsp_vld (rsp_vld),
        .err     (err)
    );

endmodule

// File: rtl/clkcfg_regbank_chk.sv
module clkcfg_regbank_chk
    import clkcfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              rsp_vld,
    input logic              err
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] FIRST_OOR = IDX_W'(NREG);
    localparam logic [IDX_W-1:0] RST_STAT  = IDX_W'(3);

    AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |=> rsp_vld); // R3

    AST_QUIET_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |=> (!rsp_vld && !err)); // R10

    AST_ERR_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rsp_vld); // R10

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[ADDR_W-1:2] >= FIRST_OOR) |=> (rdata == '0 && err)); // R8

    AST_MODE_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == '0) |=> rdata[26]); // R4

    AST_RO_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1:2] == RST_STAT && addr[1:0] == 2'b00) |=> err); // R7

    AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && addr[1:0] != 2'b00) |=> err); // R2

endmodule

bind clkcfg_regbank clkcfg_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .rsp_vld (rsp_vld),
    .err     (err)
);

// File: tb/clkcfg_regbank_bench.sv
module clkcfg_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rsp_vld;
    logic        err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] model [NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    clkcfg_regbank u_clkcfg_regbank (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rsp_vld(rsp_vld), .err(err)
    );

    function automatic logic [31:0] m_init(int i);
        logic [31:0] t [NW];
        foreach (t[k]) t[k] = 32'h0;
        t[0] = 32'h074B0B7D; t[1] = 32'hFF870B48; t[2] = 32'h49FCFE7F;
        t[3] = 32'h007F0000; t[4] = 32'h04001800; t[5] = 32'h04051C03;
        t[6] = 32'h04043001; t[7] = 32'h00000280; t[8] = '1; t[9] = '1;
        t[10] = '1; t[11] = '1; t[18] = 32'h00004040; t[23] = 32'h80209828;
        t[24] = 32'h00AA0000; t[25] = 32'h00000285;
        return t[i];
    endfunction

    function automatic logic [31:0] m_store(int i, logic [31:0] d, logic [31:0] old);
        if (i == 0) return (d & 32'h3B6FDFFF) | 32'h04000000;
        if (i == 1) return d & 32'hFF9F3FFF;
        if (i == 4 || i == 6) return d & 32'hBFFF3FFF;
        if (i == 2 || (i >= 8 && i <= 10)) return d;
        return old;
    endfunction

    function automatic bit m_can_write(int i);
        return (i <= 2) || i == 4 || i == 6 || (i >= 8 && i <= 10);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, compare response at the next negedge
    task automatic access(bit rd, bit wr, logic [11:0] a, logic [31:0] d, string req);
        int          idx = int'(a[11:2]);
        bit          ok_addr = (a[1:0] == 2'b00) && idx < NW;
        bit          ok_wr = ok_addr && m_can_write(idx);
        logic [31:0] e_data = (rd && ok_addr) ? model[idx] : 32'h0;
        logic        e_vld = rd || wr;
        logic        e_err = (rd && !ok_addr) || (wr && !ok_wr);
        rd_en = rd; wr_en = wr; addr = a; wdata = d;
        if (wr && ok_wr) model[idx] = m_store(idx, d, model[idx]);
        @(negedge clk);
        check(req, "rsp_vld", 32'(rsp_vld), 32'(e_vld));
        check(req, "err", 32'(err), 32'(e_err));
        check(req, "rdata", rdata, e_data);
    endtask

    task automatic idle();
        access(1'b0, 1'b0, 12'h0, 32'h0, "R10");
    endtask

    task automatic read_all(string req);
        for (int i = 0; i < NW; i++) access(1'b1, 1'b0, 12'(i * 4), 32'h0, req);
        idle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) model[i] = m_init(i);
        repeat (3) @(negedge clk);
        check("R1", "rsp_vld in reset", 32'(rsp_vld), 32'h0);
        check("R1", "err in reset", 32'(err), 32'h0);
        check("R1", "rdata in reset", rdata, 32'h0);
        rst_n = 1'b1;
        idle();
        read_all("R1");

        // Masked and full writes, each read back at once (R12)
        access(1'b0, 1'b1, 12'h000, 32'hFFFFFFFF, "R4");
        access(1'b1, 1'b0, 12'h000, 32'h0, "R4");
        access(1'b0, 1'b1, 12'h000, 32'h00000000, "R4");
        access(1'b1, 1'b0, 12'h000, 32'h0, "R4");
        access(1'b0, 1'b1, 12'h004, 32'hFFFFFFFF, "R5");
        access(1'b1, 1'b0, 12'h004, 32'h0, "R5");
        access(1'b0, 1'b1, 12'h010, 32'hFFFFFFFF, "R5");
        access(1'b1, 1'b0, 12'h010, 32'h0, "R5");
        access(1'b0, 1'b1, 12'h018, 32'h5555AAAA, "R5");
        access(1'b1, 1'b0, 12'h018, 32'h0, "R5");
        access(1'b0, 1'b1, 12'h008, 32'hA5A55A5A, "R6");
        access(1'b0, 1'b1, 12'h020, 32'h12345678, "R6");
        access(1'b0, 1'b1, 12'h024, 32'h00000000, "R6");
        access(1'b0, 1'b1, 12'h028, 32'hDEADBEEF, "R6");
        access(1'b1, 1'b0, 12'h028, 32'h0, "R12");
        read_all("R6");

        // Read-only words ignore writes
        for (int i = 0; i < NW; i++)
            if (!m_can_write(i)) access(1'b0, 1'b1, 12'(i * 4), 32'h0F0F0F0F, "R7");
        read_all("R7");

        // Out of range and misaligned
        access(1'b1, 1'b0, 12'(NW * 4), 32'h0, "R8");
        access(1'b1, 1'b0, 12'hFFC, 32'h0, "R8");
        access(1'b0, 1'b1, 12'(NW * 4), 32'hFFFFFFFF, "R9");
        access(1'b0, 1'b1, 12'hFFC, 32'hFFFFFFFF, "R9");
        access(1'b1, 1'b0, 12'h001, 32'h0, "R2");
        access(1'b0, 1'b1, 12'h00A, 32'h0, "R2");
        access(1'b0, 1'b1, 12'h023, 32'h0, "R2");
        read_all("R9");

        // Read and write in the same cycle
        access(1'b1, 1'b1, 12'h008, 32'h11112222, "R11");
        access(1'b1, 1'b1, 12'h008, 32'h33334444, "R11");
        access(1'b1, 1'b1, 12'h000, 32'h00000000, "R11");
        access(1'b1, 1'b1, 12'h00C, 32'hFFFFFFFF, "R11");
        access(1'b1, 1'b1, 12'(NW * 4), 32'hFFFFFFFF, "R11");
        access(1'b1, 1'b1, 12'h006, 32'h0, "R11");
        access(1'b1, 1'b0, 12'h008, 32'h0, "R11");
        idle();

        // Random mixed traffic against the model
        for (int n = 0; n < 2000; n++) begin
            logic [11:0] a;
            a = (($urandom % 8) == 0) ? 12'($urandom) : 12'(($urandom % 28) * 4);
            access(1'(($urandom % 2) == 0), 1'(($urandom % 3) == 0), a, 32'($urandom), "R12");
        end
        idle();
        read_all("R12");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule